// File: doc/BRIEF.md
# Inter-core doorbell mailbox

This block gives every core of a cluster one 32-bit doorbell word for inter-processor interrupts. A core rings another core by writing a mask of ones into the target's set window. Each one in the mask raises the matching doorbell bit. The target core reads its word through its clear window. It acknowledges the bits it has serviced by writing ones back to that same clear window. Because setting and clearing each have their own write-one address, no core ever needs a read-modify-write. To ring several cores, software writes each target's set window in turn.

Each core has a one-bit enable in its own control word. The interrupt request to a core is high while any bit of its doorbell word is set and its enable is on. The block sits behind one simple memory-mapped port. Any arbitration between cores happens upstream, so at most one access arrives per cycle.

The address map uses byte addresses. The per-core set words sit at `16*N`. The per-core clear words sit at `W + 16*N`, where `W = 16*NUM_CORES`. The per-core control words sit at `2*W + 4*N`. With the default of four cores these are 0x00/0x10/0x20/0x30 for set, 0x40/0x50/0x60/0x70 for clear, and 0x80/0x84/0x88/0x8C for control.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset every doorbell word is zero, every enable is off, every `irq_o` bit is low and `rvalid_o` is low.
- R2: A write to set address `16*N` ORs `wdata_i` into doorbell word N from the next clock edge on. The other cores' words are left unchanged.
- R3: A write to clear address `W + 16*N` clears every bit of doorbell word N that is 1 in `wdata_i`. Bits written as 0 keep their value.
- R4: A read (`req_i`=1, `we_i`=0) gives `rvalid_o`=1 in the next cycle, with `rdata_o` holding the value at the time of the request. A clear address returns doorbell word N. A control address returns the enable in bit 0 and zeros above. A set address returns zero.
- R5: A write to control address `2*W + 4*N` loads bit 0 of `wdata_i` into core N's enable. Bits 31..1 are ignored.
- R6: `irq_o[N]` is high exactly when doorbell word N is non-zero and core N's enable is 1. It follows the register state with no extra delay.
- R7: While its enable is off, a core's doorbell bits are still set and cleared as usual. Only `irq_o` is held low.
- R8: Accesses to a misaligned address (bits 1..0 not zero), to a non-zero word inside a 16-byte slot, or beyond the last control word are decoded to nothing. Writes there change no state. Reads there return zero with `rvalid_o`=1.
- R9: Reads have no side effect: reading a clear address leaves the doorbell word intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data / bit mask |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |
| irq_o | output | NUM_CORES | Per-core doorbell interrupt request |

## Verification
The bench targets four corners:
- Cross-core isolation. A decoder that drops or aliases a core-index bit would set or clear the wrong core's word. This shows up as a mismatch in another core's readback or `irq_o`.
- Partial clears. A clear window that overwrote the word instead of masking it would lose bits that were never acknowledged.
- Holes in the map: misaligned addresses, the unused words inside a slot, and addresses past the control words. A decoder that ignored the low address bits would let these writes land on a real register.
- Enable gating while doorbells are pending. Raising `irq_o` regardless of the enable, or dropping bits while the core is disabled, both show up as mismatches against the bench model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned DB_W       = 32;
  localparam int unsigned SLOT_BYTES = 16;  // per-core stride of set and clear windows
  localparam int unsigned CTL_BYTES  = 4;
  localparam int unsigned SLOT_SH    = $clog2(SLOT_BYTES);
  localparam int unsigned CTL_SH     = $clog2(CTL_BYTES);

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_SET  = 2'd1,
    REG_CLR  = 2'd2,
    REG_CTL  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CW        = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [CW-1:0]     core_o
);
  localparam int unsigned WIN     = NUM_CORES * SLOT_BYTES;
  localparam int unsigned CTL_END = 2 * WIN + NUM_CORES * CTL_BYTES;

  logic [31:0] a;
  logic [31:0] off;

  always_comb begin
    a      = 32'(addr_i);
    off    = '0;
    kind_o = REG_NONE;
    core_o = '0;
    if (a[1:0] == 2'b00) begin
      if (a < WIN) begin
        off = a;
        if ((off & (SLOT_BYTES - 1)) == 0) begin
          kind_o = REG_SET;
          core_o = CW'(off >> SLOT_SH);
        end
      end else if (a < 2 * WIN) begin
        off = a - WIN;
        if ((off & (SLOT_BYTES - 1)) == 0) begin
          kind_o = REG_CLR;
          core_o = CW'(off >> SLOT_SH);
        end
      end else if (a < CTL_END) begin
        off    = a - 2 * WIN;
        kind_o = REG_CTL;
        core_o = CW'(off >> CTL_SH);
      end
    end
  end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic            ctl_i,
  input  logic [DB_W-1:0] wdata_i,
  output logic [DB_W-1:0] mb_o,
  output logic            en_o,
  output logic            irq_o
);
  logic [DB_W-1:0] mb_q, mb_d, set_m, clr_m;
  logic            en_q;

  assign set_m = set_i ? wdata_i : '0;
  assign clr_m = clr_i ? wdata_i : '0;
  // set applied after clear: a simultaneous set never loses a doorbell
  assign mb_d  = (mb_q & ~clr_m) | set_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mb_q <= '0;
      en_q <= 1'b0;
    end else begin
      mb_q <= mb_d;
      if (ctl_i) en_q <= wdata_i[0];
    end
  end

  assign mb_o  = mb_q;
  assign en_o  = en_q;
  assign irq_o = en_q & (|mb_q);
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CW        = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_i,
  input  reg_kind_e                 kind_i,
  input  logic [CW-1:0]             core_i,
  input  logic [NUM_CORES*DB_W-1:0] mb_i,
  input  logic [NUM_CORES-1:0]      en_i,
  output logic                      rvalid_o,
  output logic [DB_W-1:0]           rdata_o
);
  logic [DB_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    unique case (kind_i)
      REG_CLR: rd_d = mb_i[core_i*DB_W +: DB_W];
      REG_CTL: rd_d = DB_W'(en_i[core_i]);
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      rdata_o  <= rd_i ? rd_d : '0;
    end
  end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DB_W-1:0]      wdata_i,
  output logic                 rvalid_o,
  output logic [DB_W-1:0]      rdata_o,
  output logic [NUM_CORES-1:0] irq_o
);
  localparam int unsigned CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  reg_kind_e                 kind;
  logic [CW-1:0]             core;
  logic                      wr, rd;
  logic [NUM_CORES*DB_W-1:0] mb_flat;
  logic [NUM_CORES-1:0]      en_vec;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  mbx_addr_dec #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .CW(CW)) u_dec (
    .addr_i (addr_i),
    .kind_o (kind),
    .core_o (core)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic hit;
    assign hit = wr && (core == CW'(c));
    mbx_bank u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (hit && (kind == REG_SET)),
      .clr_i   (hit && (kind == REG_CLR)),
      .ctl_i   (hit && (kind == REG_CTL)),
      .wdata_i (wdata_i),
      .mb_o    (mb_flat[c*DB_W +: DB_W]),
      .en_o    (en_vec[c]),
      .irq_o   (irq_o[c])
    );
  end

  mbx_rd_port #(.NUM_CORES(NUM_CORES), .CW(CW)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd),
    .kind_i   (kind),
    .core_i   (core),
    .mb_i     (mb_flat),
    .en_i     (en_vec),
    .rvalid_o (rvalid_o),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_i,
  input logic                      we_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [DB_W-1:0]           wdata_i,
  input logic                      rvalid_i,
  input logic [NUM_CORES*DB_W-1:0] mb_i,
  input logic [NUM_CORES-1:0]      irq_i
);
  localparam int unsigned WIN = NUM_CORES * SLOT_BYTES;

  p_rvalid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_i);

  p_no_rvalid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_i);

  p_read_no_effect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(mb_i));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    p_set_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == ADDR_W'(c * SLOT_BYTES))
      |=> ((mb_i[c*DB_W +: DB_W] & $past(wdata_i)) == $past(wdata_i)));

    p_clear_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == ADDR_W'(WIN + c * SLOT_BYTES))
      |=> ((mb_i[c*DB_W +: DB_W] & $past(wdata_i)) == '0));

    p_irq_needs_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mb_i[c*DB_W +: DB_W] == '0) |-> !irq_i[c]);
  end
endmodule

bind mbx_doorbell mbx_doorbell_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rvalid_i (rvalid_o),
  .mb_i     (mb_flat),
  .irq_i    (irq_o)
);

// File: tb/mbx_doorbell_tb_top.sv
`timescale 1ns/1ps
module mbx_doorbell_tb_top;
  localparam int NC = 4;
  localparam int AW = 8;
  localparam int WIN = NC * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          rvalid;
  logic [31:0]   rdata;
  logic [NC-1:0] irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mb_m [NC];
  logic        en_m [NC];

  always #2 clk = ~clk;

  mbx_doorbell #(.NUM_CORES(NC), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = en_m[c] && (mb_m[c] != 0);
    return v;
  endfunction

  function automatic logic [31:0] exp_read(int a);
    if (a[1:0] != 0) return 0;
    if (a < WIN) return 0;
    if (a < 2 * WIN) return ((a - WIN) % 16 == 0) ? mb_m[(a - WIN) / 16] : 0;
    if (a < 2 * WIN + 4 * NC) return {31'b0, en_m[(a - 2 * WIN) / 4]};
    return 0;
  endfunction

  function automatic void model_write(int a, logic [31:0] d);
    if (a[1:0] != 0) return;
    if (a < WIN) begin
      if (a % 16 == 0) mb_m[a / 16] |= d;
    end else if (a < 2 * WIN) begin
      if ((a - WIN) % 16 == 0) mb_m[(a - WIN) / 16] &= ~d;
    end else if (a < 2 * WIN + 4 * NC) begin
      en_m[(a - 2 * WIN) / 4] = d[0];
    end
  endfunction

  task automatic bus_wr(int a, logic [31:0] d, string r);
    @(negedge clk);
    req = 1; we = 1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    model_write(a, d);
    chk({r, "/R6 irq"}, 32'(irq), 32'(exp_irq()));
  endtask

  task automatic bus_rd(int a, string r);
    logic [31:0] e;
    e = exp_read(a);
    @(negedge clk);
    req = 1; we = 0; addr = AW'(a);
    @(negedge clk);
    req = 0;
    chk({r, "/R4 rvalid"}, 32'(rvalid), 1);
    chk(r, rdata, e);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int a, k, c;
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NC; i++) begin mb_m[i] = 0; en_m[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rvalid", 32'(rvalid), 0);
    rst_n = 1;
    for (int i = 0; i < NC; i++) bus_rd(WIN + 16 * i, "R1 mailbox");
    for (int i = 0; i < NC; i++) bus_rd(2 * WIN + 4 * i, "R1 enable");

    // R2 set isolated to one core
    bus_wr(16 * 3, 32'h8000_0011, "R2");
    for (int i = 0; i < NC; i++) bus_rd(WIN + 16 * i, "R2 readback");
    bus_wr(16 * 3, 32'h0000_0100, "R2");
    bus_rd(WIN + 48, "R2 or-in");
    // R4 set window reads zero
    bus_rd(48, "R4 set window");
    // R9 read leaves word intact
    bus_rd(WIN + 48, "R9 reread");
    // R7 bits kept while disabled, irq low
    chk("R7 irq off", 32'(irq), 0);
    // R5 upper control bits ignored
    bus_wr(2 * WIN + 12, 32'hFFFF_FFFE, "R5");
    bus_rd(2 * WIN + 12, "R5 bit0 only");
    bus_wr(2 * WIN + 12, 32'hFFFF_FFFF, "R5");
    bus_rd(2 * WIN + 12, "R5 enable");
    chk("R6 irq on", 32'(irq), 32'h8);
    // R3 partial clear
    bus_wr(WIN + 48, 32'h8000_0001, "R3");
    bus_rd(WIN + 48, "R3 partial");
    bus_wr(WIN + 48, 32'hFFFF_FFFF, "R3");
    chk("R6 irq drops", 32'(irq), 0);
    // R8 holes in the map
    bus_wr(1, 32'hFFFF_FFFF, "R8 misaligned");
    bus_wr(4, 32'hFFFF_FFFF, "R8 slot hole");
    bus_wr(16 + 8, 32'hFFFF_FFFF, "R8 slot hole");
    bus_wr(2 * WIN + 4 * NC, 32'hFFFF_FFFF, "R8 past end");
    bus_wr(2 * WIN + 4 * NC + 4, 32'hFFFF_FFFF, "R8 past end");
    for (int i = 0; i < NC; i++) bus_rd(WIN + 16 * i, "R8 no write");
    bus_rd(WIN + 4, "R8 hole read");
    bus_rd(255, "R8 misaligned read");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      k = int'($urandom_range(0, 6));
      c = int'($urandom_range(0, NC - 1));
      d = $urandom();
      if ($urandom_range(0, 1) == 1) d = d & $urandom();
      case (k)
        0, 1: bus_wr(16 * c, d, "R2 rnd");
        2: bus_wr(WIN + 16 * c, ($urandom_range(0, 1) == 1) ? mb_m[c] & d : d, "R3 rnd");
        3: bus_wr(2 * WIN + 4 * c, d, "R5 rnd");
        4: begin a = int'($urandom_range(0, 255)); bus_wr(a, d, "R8 rnd"); end
        5: bus_rd(WIN + 16 * c, "R4 rnd");
        default: begin a = int'($urandom_range(0, 255)); bus_rd(a, "R8 rnd read"); end
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule